// File: doc/BRIEF.md
# Variable-Count Bit Gearbox

This block sits behind a sample picker that delivers between zero and ten good bits per clock. Each cycle it receives a 10-bit bundle whose valid bits sit at the low end, plus a 4-bit count of how many of them are valid. It appends those bits, in arrival order, to a residue store. Each time a full output word has built up, it emits the word with a one-cycle enable. Everything runs on one clock.

A mode input picks the output word width. The narrow mode gives 10-bit words, which suit a block-code decoder. The wide mode gives 16-bit words, which suit byte-oriented framings. The block does not search for word alignment. It only packs bits in the order they arrive, and the oldest bit always lands in bit 0. Because the input count varies and neither word width is a multiple of it, leftover bits carry from one word into the next through a variable shift.

Top module: `bit_gearbox`

## Requirements
- R1: While reset is asserted, and right after it, `word_en` and `word_out` are 0 and no bits are held over, so the first word after reset holds only bits received after reset.
- R2: Only the low `in_cnt` bits of `in_bits` are taken; bits at or above position `in_cnt` have no effect on any output word.
- R3: An `in_cnt` value from 11 to 15 is treated as 10.
- R4: Bits are packed LSB-first with no gaps: the oldest pending bit goes to `word_out[0]`, and the following bits go to the next higher positions in arrival order.
- R5: With `mode_wide`=0 each word is 10 bits and `word_out[15:10]` reads 0 whenever `word_en` is high.
- R6: With `mode_wide`=1 each word is 16 bits in `word_out[15:0]`.
- R7: `word_en` is high for exactly one cycle per completed word. This is the cycle after the clock edge that samples the input completing the word. At most one word is produced per cycle.
- R8: At ten valid bits every cycle, in either mode, no bit is lost. The number of pending bits never exceeds the word width minus one after an edge.
- R9: `word_out` keeps its last value while `word_en` is low.
- R10: A cycle with `in_cnt`=0 adds nothing; while fewer than 10 bits are pending, it produces no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wide | input | 1 | 0: 10-bit words, 1: 16-bit words |
| in_bits | input | 10 | Incoming bits, valid ones LSB-aligned, bit 0 oldest |
| in_cnt | input | 4 | Number of valid bits in `in_bits` |
| word_out | output | 16 | Packed output word |
| word_en | output | 1 | One-cycle strobe marking a new word on `word_out` |

## Verification
The tests use several input patterns:
- **Steady ten-bit input in narrow mode.** Each word must equal the bundle that completes it, which exposes any offset or bit reversal.
- **Steady ten-bit input in wide mode.** The residue wraps through every fill level and the run reaches the 5-words-per-8-cycles ceiling, which shows up lost or duplicated bits.
- **Mixed counts, including zero and single bits.** These exercise every append offset.
- **Garbage above the count, and counts above ten.** These separate correct masking and clamping from a design that simply trusts the count.
- **A mode switch and a reset with bits pending.** These show whether the leftover bits carry across the switch and are cleared by reset.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  typedef enum logic {
    GBX_NARROW = 1'b0,
    GBX_WIDE   = 1'b1
  } gbx_mode_e;

  function automatic gbx_mode_e gbx_mode(input logic sel);
    return sel ? GBX_WIDE : GBX_NARROW;
  endfunction
endpackage

// File: rtl/gbx_rst_sync.sv
module gbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gbx_append.sv
module gbx_append #(
  parameter int IN_W   = 10,
  parameter int CNT_W  = 4,
  parameter int BUF_W  = 25,
  parameter int FILL_W = 5
) (
  input  logic [BUF_W-1:0]  buf_q,
  input  logic [FILL_W-1:0] fill_q,
  input  logic [IN_W-1:0]   in_bits,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic [BUF_W-1:0]  merged,
  output logic [FILL_W-1:0] total
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(IN_W);

  logic [CNT_W-1:0] cnt_eff;
  logic [IN_W-1:0]  kept;

  // counts beyond the bundle width saturate at the bundle width
  assign cnt_eff = (in_cnt > CNT_MAX) ? CNT_MAX : in_cnt;

  // per-bit qualification: only positions below the count survive
  for (genvar i = 0; i < IN_W; i++) begin : g_keep
    assign kept[i] = in_bits[i] & (CNT_W'(i) < cnt_eff);
  end

  always_comb begin
    merged = buf_q | ({{(BUF_W-IN_W){1'b0}}, kept} << fill_q);
    total  = fill_q + FILL_W'(cnt_eff);
  end
endmodule

// File: rtl/gbx_emit.sv
module gbx_emit
  import gbx_pkg::*;
#(
  parameter int BUF_W    = 25,
  parameter int FILL_W   = 5,
  parameter int NARROW_W = 10,
  parameter int WIDE_W   = 16
) (
  input  gbx_mode_e         mode,
  input  logic [BUF_W-1:0]  merged,
  input  logic [FILL_W-1:0] total,
  output logic              fire,
  output logic [WIDE_W-1:0] word,
  output logic [BUF_W-1:0]  rest,
  output logic [FILL_W-1:0] rest_fill
);
  localparam logic [FILL_W-1:0] NARROW_F = FILL_W'(NARROW_W);
  localparam logic [FILL_W-1:0] WIDE_F   = FILL_W'(WIDE_W);

  logic [FILL_W-1:0] width;
  logic [WIDE_W-1:0] word_narrow;
  logic [WIDE_W-1:0] word_wide;

  assign word_narrow = WIDE_W'(merged[NARROW_W-1:0]);
  assign word_wide   = merged[WIDE_W-1:0];

  always_comb begin
    width     = (mode == GBX_WIDE) ? WIDE_F : NARROW_F;
    fire      = (total >= width);
    word      = (mode == GBX_WIDE) ? word_wide : word_narrow;
    rest      = fire ? (merged >> width) : merged;
    rest_fill = fire ? (total - width) : total;
  end
endmodule

// File: rtl/bit_gearbox.sv
module bit_gearbox
  import gbx_pkg::*;
#(
  parameter int IN_W     = 10,
  parameter int CNT_W    = 4,
  parameter int NARROW_W = 10,
  parameter int WIDE_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic [IN_W-1:0]   in_bits,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic [WIDE_W-1:0] word_out,
  output logic              word_en
);
  localparam int BUF_W  = WIDE_W - 1 + IN_W;
  localparam int FILL_W = $clog2(BUF_W + 1);

  logic              rst_sync_n;
  logic [BUF_W-1:0]  buf_q, buf_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [WIDE_W-1:0] word_q, word_d;
  logic              en_q;
  logic [BUF_W-1:0]  merged;
  logic [FILL_W-1:0] total;
  logic              fire;
  logic [WIDE_W-1:0] word_c;
  logic [BUF_W-1:0]  rest;
  logic [FILL_W-1:0] rest_fill;

  gbx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  gbx_append #(.IN_W(IN_W), .CNT_W(CNT_W), .BUF_W(BUF_W), .FILL_W(FILL_W)) u_app (
    .buf_q(buf_q), .fill_q(fill_q), .in_bits(in_bits), .in_cnt(in_cnt),
    .merged(merged), .total(total)
  );

  gbx_emit #(.BUF_W(BUF_W), .FILL_W(FILL_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_emit (
    .mode(gbx_mode(mode_wide)), .merged(merged), .total(total),
    .fire(fire), .word(word_c), .rest(rest), .rest_fill(rest_fill)
  );

  // next state
  always_comb begin
    buf_d  = rest;
    fill_d = rest_fill;
    word_d = fire ? word_c : word_q;
  end

  // residue registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      buf_q  <= '0;
      fill_q <= '0;
    end else begin
      buf_q  <= buf_d;
      fill_q <= fill_d;
    end
  end

  // output registers, word loads only on a completed word
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= fire;
      if (fire) word_q <= word_d;
    end
  end

  assign word_out = word_q;
  assign word_en  = en_q;

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fill_q < FILL_W'(WIDE_W));

  // R4
  buf_clean_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_q >> fill_q) == '0);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_cnt == '0 && fill_q < FILL_W'(NARROW_W)) |=> (fill_q == $past(fill_q) && !word_en));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !word_en |-> $stable(word_out));

  // R5
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (word_en && !$past(mode_wide)) |-> word_out[WIDE_W-1:NARROW_W] == '0);
endmodule

// File: tb/bit_gearbox_tb.sv
module bit_gearbox_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wide;
  logic [9:0]  in_bits;
  logic [3:0]  in_cnt;
  logic [15:0] word_out;
  logic        word_en;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  bit          q[$];
  logic [15:0] last_word;
  bit          exp_valid;
  bit          exp_en;
  logic [15:0] exp_word;
  string       exp_tag;
  int          en_seen;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_gearbox u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide),
    .in_bits(in_bits), .in_cnt(in_cnt),
    .word_out(word_out), .word_en(word_en)
  );

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare outputs for the previous step (called at a falling edge)
  task automatic check_pending();
    if (exp_valid) begin
      check(exp_tag, "word_en", {15'd0, word_en}, {15'd0, exp_en});
      check(exp_tag, "word_out", word_out, exp_word);
      if (word_en) en_seen++;
    end
    exp_valid = 0;
  endtask

  // drive one input cycle and update the bench model
  task automatic step(input string tag, input bit wide, input logic [9:0] bits, input logic [3:0] cnt);
    int n;
    int w;
    logic [15:0] wd;
    @(negedge clk);
    check_pending();
    mode_wide = wide;
    in_bits   = bits;
    in_cnt    = cnt;
    n = (cnt > 10) ? 10 : int'(cnt);
    for (int i = 0; i < n; i++) q.push_back(bits[i]);
    w = wide ? 16 : 10;
    if (q.size() >= w) begin
      wd = '0;
      for (int i = 0; i < w; i++) wd[i] = q.pop_front();
      last_word = wd;
      exp_en = 1;
    end else begin
      exp_en = 0;
    end
    exp_word  = last_word;
    exp_tag   = tag;
    exp_valid = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    in_cnt = 4'd0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    check_pending();
    rst_n = 1'b0;
    in_cnt = 4'd0;
    q.delete();
    last_word = '0;
    @(negedge clk);
    check(tag, "word_en in reset", {15'd0, word_en}, 16'd0);
    check(tag, "word_out in reset", word_out, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tag, "word_en after reset", {15'd0, word_en}, 16'd0);
  endtask

  // R1: reset state and clearing of pending bits
  task automatic t_reset();
    do_reset("R1");
    step("R1", 1, 10'h3FF, 4'd7);
    do_reset("R1");
    step("R1", 0, 10'h2A5, 4'd10);
    flush();
  endtask

  // R4 R5: steady ten bits, narrow mode, word equals the bundle
  task automatic t_full_narrow();
    for (int i = 0; i < 20; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R5", 0, lfsr[9:0], 4'd10);
    end
    flush();
  endtask

  // R6 R8: steady ten bits, wide mode, maximum rate, no loss
  task automatic t_max_wide();
    en_seen = 0;
    for (int i = 0; i < 80; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R8", 1, lfsr[9:0], 4'd10);
    end
    flush();
    check("R8", "word count", 16'(en_seen), 16'd50);
  endtask

  // R4 R7 R9 R10: mixed counts with zeros and single bits
  task automatic t_mixed();
    for (int i = 0; i < 60; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R7", i[0], lfsr[9:0], 4'(lfsr[13:10] % 11));
    end
    for (int i = 0; i < 5; i++) step("R10", 0, 10'h3FF, 4'd0);
    for (int i = 0; i < 40; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R9", 1, lfsr[9:0], 4'd1);
    end
    flush();
  endtask

  // R2: garbage above the count is dropped
  task automatic t_mask();
    for (int i = 0; i < 30; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R2", i[1], lfsr[9:0] | 10'h3C0, 4'(1 + (i % 6)));
    end
    flush();
  endtask

  // R3: counts 11..15 behave as 10
  task automatic t_clamp();
    for (int i = 0; i < 20; i++) begin
      lfsr = lfsr_next(lfsr);
      step("R3", i[2], lfsr[9:0], 4'(11 + (i % 5)));
    end
    flush();
  endtask

  // R6: pending bits carry across a mode switch
  task automatic t_switch();
    step("R6", 1, 10'h155, 4'd9);
    step("R6", 1, 10'h0F3, 4'd5);
    step("R6", 0, 10'h3C7, 4'd10);
    step("R6", 1, 10'h2B4, 4'd10);
    step("R6", 0, 10'h111, 4'd3);
    flush();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_wide = 1'b0; in_bits = '0; in_cnt = '0;
    last_word = '0; exp_valid = 0; exp_en = 0; exp_word = '0; exp_tag = "";
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_full_narrow();
    t_max_wide();
    t_mixed();
    t_mask();
    t_clamp();
    t_switch();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule